// File: doc/BRIEF.md
# Fractional-increment time counter

This block keeps a free-running time value for precision time keeping. A 96-bit accumulator holds whole nanoseconds in its upper 64 bits and a binary fraction of a nanosecond in its lower 32 bits. On each core clock cycle while counting is switched on, a programmable 32.32 fixed-point increment is added to it. The increment is not fixed at one, so software can match the count to any core clock frequency. For a clock of f Hz the nominal increment is (10^9 × 2^32) / f; at 800 MHz that is 1.25 ns. Software can then trim the rate at run time in steps finer than a nanosecond.

Software reaches the block through a small register port. A request is valid for one cycle and is either a read or a write, and a read answers one cycle later. Through this port software starts and stops the count, sets the starting time, reads the whole and fractional parts of the time, and rewrites the increment while the counter runs.

Top module: `ftc_top`

## Requirements
- R1: After reset the enable bit, the accumulator and the increment are all zero, so reads of the configuration (0xF00), time-low (0xF08), time-high (0xF10) and increment (0xF18) offsets return zero.
- R2: The accumulator advances only on cycles when bit 0 of the configuration register is 1. While that bit is 0 the time holds its value. A configuration read returns the enable bit in bit 0 and zero in bits 63:1.
- R3: A counter enabled for N cycles with increment C, starting from time S, holds S + N×C. Bits 63:32 of C are whole nanoseconds and bits 31:0 are the fraction. A time-high read returns accumulator bits 95:32. A time-low read returns accumulator bits 31:0 with zeros in bits 63:32.
- R4: The addition wraps modulo 2^96, so a count past the largest whole-nanosecond value continues from zero.
- R5: The increment register can be rewritten while counting. The cycle of the write still adds the old increment, every later cycle adds the new one, and the accumulated time is not otherwise changed. An increment read returns all 64 written bits.
- R6: A time-high write loads the 64-bit value into the nanosecond part and clears the fraction. It replaces that cycle's addition.
- R7: Writes to time-low and to any unmapped offset change no state. Reads of unmapped offsets return zero.
- R8: A read raises the response valid flag for exactly the next cycle. The returned data is the register value at the cycle of the read. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 64 | Read data |

## Verification
A wrong accumulator or increment state shows up at the port on the next time-high or time-low read, one cycle after the request. The runs use exact cycle counts, so one extra or missing addition changes the read value by exactly one increment. A carry lost between the fraction and the whole nanoseconds changes the time-high value by one. A lost enable or increment write shows up in the next readback of that register. A response that is early, late or missing shows up as a wrong valid flag in the cycle after the request.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_TLO,
        SEL_THI,
        SEL_INC
    } reg_sel_e;
endpackage

// File: rtl/ftc_decode.sv
module ftc_decode #(
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] OFF_CFG = 12'hF00,
    parameter logic [11:0] OFF_TLO = 12'hF08,
    parameter logic [11:0] OFF_THI = 12'hF10,
    parameter logic [11:0] OFF_INC = 12'hF18
) (
    input  logic [ADDR_W-1:0] addr,
    output ftc_pkg::reg_sel_e sel
);
    always_comb begin
        if (addr == ADDR_W'(OFF_CFG))      sel = ftc_pkg::SEL_CFG;
        else if (addr == ADDR_W'(OFF_TLO)) sel = ftc_pkg::SEL_TLO;
        else if (addr == ADDR_W'(OFF_THI)) sel = ftc_pkg::SEL_THI;
        else if (addr == ADDR_W'(OFF_INC)) sel = ftc_pkg::SEL_INC;
        else                               sel = ftc_pkg::SEL_NONE;
    end
endmodule

// File: rtl/ftc_regs.sv
module ftc_regs #(
    parameter int DATA_W = 64,
    parameter int FRAC_W = 32,
    localparam int ACC_W = DATA_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  ftc_pkg::reg_sel_e sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ACC_W-1:0]  acc,
    output logic              en,
    output logic [DATA_W-1:0] inc,
    output logic              load,
    output logic [DATA_W-1:0] load_ns,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] inc;
        logic              rvld;
        logic [DATA_W-1:0] rdat;
    } regs_t;

    regs_t q, d;
    logic  wr_hit, rd_hit;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        wr_hit = req_valid && req_write;
        rd_hit = req_valid && !req_write;
        case (sel)
            ftc_pkg::SEL_CFG: rd_mux = {{(DATA_W-1){1'b0}}, q.en};
            ftc_pkg::SEL_TLO: rd_mux = {{(DATA_W-FRAC_W){1'b0}}, acc[FRAC_W-1:0]};
            ftc_pkg::SEL_THI: rd_mux = acc[ACC_W-1:FRAC_W];
            ftc_pkg::SEL_INC: rd_mux = q.inc;
            default:          rd_mux = '0;
        endcase
        d      = q;
        d.rvld = rd_hit;
        if (rd_hit) d.rdat = rd_mux;
        if (wr_hit) begin
            case (sel)
                ftc_pkg::SEL_CFG: d.en  = wdata[0];
                ftc_pkg::SEL_INC: d.inc = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en        = q.en;
    assign inc       = q.inc;
    assign load      = wr_hit && (sel == ftc_pkg::SEL_THI);
    assign load_ns   = wdata;
    assign rsp_valid = q.rvld;
    assign rsp_rdata = q.rdat;

    // R7
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (sel == ftc_pkg::SEL_TLO || sel == ftc_pkg::SEL_NONE))
        |=> ($stable(en) && $stable(inc)));
endmodule

// File: rtl/ftc_accum.sv
module ftc_accum #(
    parameter int DATA_W = 64,
    parameter int FRAC_W = 32,
    localparam int ACC_W = DATA_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] inc,
    input  logic              load,
    input  logic [DATA_W-1:0] load_ns,
    output logic [ACC_W-1:0]  acc
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t q, d;
    logic [ACC_W-1:0] inc_ext;

    always_comb begin
        inc_ext = {{(ACC_W-DATA_W){1'b0}}, inc};
        d = q;
        if (load)    d.acc = {load_ns, {FRAC_W{1'b0}}};
        else if (en) d.acc = q.acc + inc_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign acc = q.acc;

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(acc));

    // R6
    load_clears_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc[FRAC_W-1:0] == '0 && acc[ACC_W-1:FRAC_W] == $past(load_ns)));
endmodule

// File: rtl/ftc_top.sv
module ftc_top #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64,
    parameter int FRAC_W = 32,
    localparam int ACC_W = DATA_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    ftc_pkg::reg_sel_e sel_w;
    logic              en_w, load_w;
    logic [DATA_W-1:0] inc_w, load_ns_w;
    logic [ACC_W-1:0]  acc_w;

    ftc_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (req_addr),
        .sel  (sel_w)
    );

    ftc_regs #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .sel       (sel_w),
        .wdata     (req_wdata),
        .acc       (acc_w),
        .en        (en_w),
        .inc       (inc_w),
        .load      (load_w),
        .load_ns   (load_ns_w),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    ftc_accum #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_w),
        .inc     (inc_w),
        .load    (load_w),
        .load_ns (load_ns_w),
        .acc     (acc_w)
    );

    // R3
    step_by_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && !load_w) |=> (acc_w - $past(acc_w) == {{(ACC_W-DATA_W){1'b0}}, $past(inc_w)}));

    // R8
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R8
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: tb/test_ftc_top.sv
module test_ftc_top;
    localparam logic [11:0] A_CFG = 12'hF00, A_TLO = 12'hF08, A_THI = 12'hF10, A_INC = 12'hF18;

    logic        clk = 1'b0;
    logic        rst_n, req_valid, req_write;
    logic [11:0] req_addr;
    logic [63:0] req_wdata, rsp_rdata;
    logic        rsp_valid;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    ftc_top i_ftc_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic [63:0] start;
        logic [63:0] inc;
        logic [15:0] n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{64'd0,              64'h0000_0001_4000_0000, 16'd8},
        '{64'd100,            64'h0000_0000_8000_0000, 16'd5},
        '{64'd0,              64'h0000_0000_C000_0000, 16'd6},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000, 16'd3},
        '{64'd7,              64'd0,                   16'd4},
        '{64'h1234,           64'hFFFF_FFFF_FFFF_FFFF, 16'd2}
    };

    function automatic logic [95:0] model(logic [63:0] s, logic [63:0] c, int n);
        return {s, 32'h0} + 96'(n) * {32'h0, c};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic wr(logic [11:0] a, logic [63:0] dt);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = dt;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R8 no response to write", 64'(rsp_valid), 64'd0);
    endtask

    task automatic rd(logic [11:0] a, output logic [63:0] dt);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check("R8 read response valid", 64'(rsp_valid), 64'd1);
        dt = rsp_rdata;
    endtask

    task automatic run(logic [63:0] s, logic [63:0] c, int n);
        wr(A_CFG, 64'd0);
        wr(A_THI, s);
        wr(A_INC, c);
        wr(A_CFG, 64'd1);
        repeat (n - 1) @(negedge clk);
        wr(A_CFG, 64'd0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] r, r2;
        logic [95:0] e;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle no response", 64'(rsp_valid), 64'd0);

        // R1 reset values
        rd(A_CFG, r); check("R1 cfg", r, 64'd0);
        rd(A_THI, r); check("R1 time high", r, 64'd0);
        rd(A_TLO, r); check("R1 time low", r, 64'd0);
        rd(A_INC, r); check("R1 increment", r, 64'd0);

        // R3 R4 vector table
        foreach (VECS[i]) begin
            run(VECS[i].start, VECS[i].inc, int'(VECS[i].n));
            e = model(VECS[i].start, VECS[i].inc, int'(VECS[i].n));
            rd(A_THI, r); check($sformatf("R3/R4 vec %0d high", i), r, e[95:32]);
            rd(A_TLO, r); check($sformatf("R3 vec %0d low", i), r, {32'h0, e[31:0]});
        end

        // R2 stopped counter holds; cfg readback only bit 0
        wr(A_CFG, 64'hFFFF_0000_0000_0003);
        rd(A_CFG, r); check("R2 cfg readback", r, 64'd1);
        wr(A_CFG, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(A_CFG, r); check("R2 cfg cleared", r, 64'd0);
        rd(A_THI, r);
        repeat (10) @(negedge clk);
        rd(A_THI, r2); check("R2 hold while off", r2, r);

        // R5 increment change mid-run: 4 cycles of 1.25, then 6 of 2.5
        wr(A_THI, 64'd50);
        wr(A_INC, 64'h0000_0001_4000_0000);
        wr(A_CFG, 64'd1);
        repeat (3) @(negedge clk);
        wr(A_INC, 64'h0000_0002_8000_0000);
        repeat (5) @(negedge clk);
        wr(A_CFG, 64'd0);
        e = {64'd50, 32'h0} + 96'd4 * 96'h1_4000_0000 + 96'd6 * 96'h2_8000_0000;
        rd(A_THI, r); check("R5 rate change high", r, e[95:32]);
        rd(A_TLO, r); check("R5 rate change low", r, {32'h0, e[31:0]});
        rd(A_INC, r); check("R5 increment readback", r, 64'h0000_0002_8000_0000);

        // R6 time-high write while running clears fraction, then 3 adds of 1.5
        wr(A_INC, 64'h0000_0001_8000_0000);
        wr(A_CFG, 64'd1);
        repeat (4) @(negedge clk);
        wr(A_THI, 64'd1000);
        repeat (2) @(negedge clk);
        wr(A_CFG, 64'd0);
        e = {64'd1000, 32'h0} + 96'd3 * 96'h1_8000_0000;
        rd(A_THI, r); check("R6 load while running high", r, e[95:32]);
        rd(A_TLO, r); check("R6 load while running low", r, {32'h0, e[31:0]});

        // R7 ignored writes and unmapped reads
        wr(A_THI, 64'd5);
        wr(A_INC, 64'h0000_0000_1111_2222);
        wr(A_TLO, 64'h0000_0000_ABCD_0000);
        wr(12'hF20, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h000, 64'd1);
        rd(A_TLO, r); check("R7 time-low write ignored", r, 64'd0);
        rd(A_THI, r); check("R7 time high unchanged", r, 64'd5);
        rd(A_INC, r); check("R7 increment unchanged", r, 64'h0000_0000_1111_2222);
        rd(A_CFG, r); check("R7 enable unchanged", r, 64'd0);
        rd(12'hF20, r); check("R7 unmapped read F20", r, 64'd0);
        rd(12'hF04, r); check("R7 unmapped read F04", r, 64'd0);

        // R8 back-to-back reads while running one cycle apart differ by one increment
        wr(A_INC, 64'h0000_0003_0000_0000);
        wr(A_CFG, 64'd1);
        rd(A_THI, r);
        rd(A_THI, r2);
        check("R8 snapshot per read cycle", r2 - r, 64'd3);
        wr(A_CFG, 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule